// File: doc/BRIEF.md
# Dual-Link Word Port Multiplexer with Shared FIFOs

This block connects a 32-bit host data port to two link channels through one receive FIFO and one transmit FIFO. The two FIFOs are independent of each other. Words the host writes are queued in the transmit FIFO and leave on whichever link is currently selected. Words arriving on the selected link are queued in the receive FIFO and are popped by host reads. A single select input chooses the active link. Each link has its own valid/ready handshake, and each link reports whether it holds the transmit token.

The select may change on any cycle. A word stays in its FIFO until a handshake completes, so a switch loses nothing and changes no order. The deselected link sees its transmit valid and receive ready held low, which freezes its transfer until it is selected again.

A read-only status word packs the flags of both FIFOs, four sticky error flags and the token and idle state of each link.

Back-pressure rules: the host may push only when `host_wr_ready` is high; a word is taken on a cycle where valid and ready are both high. `host_rd_valid` is high while the receive FIFO holds a word, and the head word is removed on a cycle where `host_rd_ready` is also high. On the link side, the selected link's transmit word is consumed when its valid and ready are both high, and a received word is taken when its valid and ready are both high.

Top module: `commport_mux`

## Requirements
- R1: A host push with `host_wr_ready` high stores one word in the transmit FIFO, and words leave on the links in push order; `host_wr_ready` is low exactly when the transmit FIFO is full.
- R2: `host_rd_valid` is high while the receive FIFO is non-empty, `host_rd_data` shows the oldest word, and a cycle with `host_rd_ready` and `host_rd_valid` both high removes it.
- R3: `link_sel` = 0 selects link 0 and 1 selects link 1. Only the selected link shows transmit valid and receive ready; both are held low on the other link.
- R4: Changing `link_sel` between transfers loses no word and keeps order: a word not yet accepted on one link is offered next on the newly selected link.
- R5: Status bits 31 down to 24 are, in order: link 0 token, link 0 idle, link 1 token, link 1 idle, receive almost empty, receive almost full, receive empty, receive full.
- R6: Status bits 23 down to 16 are, in order: receive read error, receive write error, transmit almost empty, transmit almost full, transmit empty, transmit full, transmit read error, transmit write error.
- R7: Status bits 15 and 13 are the inverse of transmit full, bits 14 and 12 are the inverse of receive empty, and bits 11 down to 0 read as zero. After reset the status word is 0x5A28A000 with both token inputs low.
- R8: A FIFO's almost-empty flag is high when it holds 128 or fewer words.
- R9: A FIFO's almost-full flag is high when it holds 384 or more words.
- R10: A read error (host `host_rd_ready` high with the receive FIFO empty; selected link transmit ready high with the transmit FIFO empty) sets the matching flag, which stays set until reset; no FIFO content changes.
- R11: A write error (host `host_wr_valid` high with the transmit FIFO full; selected link receive valid high with the receive FIFO full) sets the matching flag, which stays set until reset; the refused word is not stored.
- R12: A link's idle flag is high when that link is deselected, or when it is selected and neither its transmit valid nor its receive valid is high.
- R13: Each FIFO holds 512 words; its full flag rises on the 512th stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_sel | input | 1 | Active link: 0 selects link 0, 1 selects link 1 |
| host_wr_valid | input | 1 | Host offers a word for transmission |
| host_wr_data | input | 32 | Host word to transmit |
| host_wr_ready | output | 1 | Transmit FIFO can take a word |
| host_rd_valid | output | 1 | Receive FIFO holds a word |
| host_rd_data | output | 32 | Oldest received word |
| host_rd_ready | input | 1 | Host pops the oldest received word |
| lk_tx_valid | output | 2 | Per-link transmit valid |
| lk_tx_data | output | 64 | Per-link transmit word (link 0 in bits 31:0) |
| lk_tx_ready | input | 2 | Per-link transmit ready |
| lk_rx_valid | input | 2 | Per-link receive valid |
| lk_rx_data | input | 64 | Per-link receive word (link 0 in bits 31:0) |
| lk_rx_ready | output | 2 | Per-link receive ready |
| lk_token | input | 2 | Per-link transmit token held |
| status | output | 32 | Packed status word |

## Verification
A wrong occupancy count shows at the ports on the cycle after the faulty push or pop, as a status flag (empty, almost empty, almost full, full) that flips one word early or late, and as a ready that rises or falls at the wrong fill level. A broken pointer shows later, when the drained words come out of order or repeat, so every fill is drained completely and compared word by word. A wrong select path shows at once as valid or ready on the deselected link, and a lost word after a switch shows as a gap in the sequence delivered on the new link. Error flags that fail to stick show on the status read after the next clean cycle.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  localparam int CPM_LINKS = 2;

  typedef struct packed {
    logic        tok0;
    logic        idle0;
    logic        tok1;
    logic        idle1;
    logic        rx_aempty;
    logic        rx_afull;
    logic        rx_empty;
    logic        rx_full;
    logic        rx_rd_err;
    logic        rx_wr_err;
    logic        tx_aempty;
    logic        tx_afull;
    logic        tx_empty;
    logic        tx_full;
    logic        tx_rd_err;
    logic        tx_wr_err;
    logic        tx_nfull_a;
    logic        rx_nempty_a;
    logic        tx_nfull_b;
    logic        rx_nempty_b;
    logic [11:0] zero;
  } cpm_status_t;
endpackage

// File: rtl/cpm_fifo.sv
module cpm_fifo #(
  parameter int W      = 32,
  parameter int DEPTH  = 512,
  parameter int MARGIN = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full,
  output logic         aempty,
  output logic         afull,
  output logic         push_fail,
  output logic         pop_fail
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_AE   = CW'(MARGIN);
  localparam logic [CW-1:0] CNT_AF   = CW'(DEPTH - MARGIN);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty     = (count == '0);
  assign full      = (count == CNT_FULL);
  assign aempty    = (count <= CNT_AE);
  assign afull     = (count >= CNT_AF);
  assign do_push   = push && !full;
  assign do_pop    = pop && !empty;
  assign push_fail = push && full;
  assign pop_fail  = pop && empty;
  assign rdata     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R13
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_FULL);

  // R1
  level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !(pop && !empty)) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/cpm_link_mux.sv
module cpm_link_mux
  import cpm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sel,
  input  logic                        tx_avail,
  input  logic [W-1:0]                tx_head,
  output logic                        tx_pop,
  output logic                        tx_pull_fail,
  input  logic                        rx_room,
  output logic                        rx_push,
  output logic [W-1:0]                rx_word,
  output logic [CPM_LINKS-1:0]        lk_tx_valid,
  output logic [CPM_LINKS-1:0][W-1:0] lk_tx_data,
  input  logic [CPM_LINKS-1:0]        lk_tx_ready,
  input  logic [CPM_LINKS-1:0]        lk_rx_valid,
  input  logic [CPM_LINKS-1:0][W-1:0] lk_rx_data,
  output logic [CPM_LINKS-1:0]        lk_rx_ready,
  output logic [CPM_LINKS-1:0]        idle
);
  logic [CPM_LINKS-1:0] active;

  for (genvar g = 0; g < CPM_LINKS; g++) begin : g_link
    assign active[g]      = (sel == g[0]);
    assign lk_tx_valid[g] = active[g] && tx_avail;
    assign lk_tx_data[g]  = active[g] ? tx_head : '0;
    assign lk_rx_ready[g] = active[g] && rx_room;
    assign idle[g]        = !active[g] || (!lk_tx_valid[g] && !lk_rx_valid[g]);
  end

  assign tx_pop       = lk_tx_ready[sel];
  assign tx_pull_fail = lk_tx_ready[sel] && !tx_avail;
  assign rx_push      = lk_rx_valid[sel];
  assign rx_word      = lk_rx_data[sel];

  // R3
  off_link_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_tx_valid[!sel] && !lk_rx_ready[!sel]);
endmodule

// File: rtl/cpm_status.sv
module cpm_status
  import cpm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CPM_LINKS-1:0] token,
  input  logic [CPM_LINKS-1:0] idle,
  input  logic                 rx_aempty,
  input  logic                 rx_afull,
  input  logic                 rx_empty,
  input  logic                 rx_full,
  input  logic                 tx_aempty,
  input  logic                 tx_afull,
  input  logic                 tx_empty,
  input  logic                 tx_full,
  input  logic                 rx_rd_ev,
  input  logic                 rx_wr_ev,
  input  logic                 tx_rd_ev,
  input  logic                 tx_wr_ev,
  output logic [31:0]          status
);
  logic rx_rd_q, rx_wr_q, tx_rd_q, tx_wr_q;
  cpm_status_t st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_rd_q <= 1'b0;
      rx_wr_q <= 1'b0;
      tx_rd_q <= 1'b0;
      tx_wr_q <= 1'b0;
    end else begin
      rx_rd_q <= rx_rd_q | rx_rd_ev;
      rx_wr_q <= rx_wr_q | rx_wr_ev;
      tx_rd_q <= tx_rd_q | tx_rd_ev;
      tx_wr_q <= tx_wr_q | tx_wr_ev;
    end
  end

  always_comb begin
    st.tok0        = token[0];
    st.idle0       = idle[0];
    st.tok1        = token[1];
    st.idle1       = idle[1];
    st.rx_aempty   = rx_aempty;
    st.rx_afull    = rx_afull;
    st.rx_empty    = rx_empty;
    st.rx_full     = rx_full;
    st.rx_rd_err   = rx_rd_q;
    st.rx_wr_err   = rx_wr_q;
    st.tx_aempty   = tx_aempty;
    st.tx_afull    = tx_afull;
    st.tx_empty    = tx_empty;
    st.tx_full     = tx_full;
    st.tx_rd_err   = tx_rd_q;
    st.tx_wr_err   = tx_wr_q;
    st.tx_nfull_a  = !tx_full;
    st.rx_nempty_a = !rx_empty;
    st.tx_nfull_b  = !tx_full;
    st.rx_nempty_b = !rx_empty;
    st.zero        = '0;
  end

  assign status = st;

  // R10
  rderr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_q || tx_rd_q) |=> (status[23] || !$past(rx_rd_q)) && (status[17] || !$past(tx_rd_q)));

  // R11
  wrerr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_wr_ev || tx_wr_ev) |=> (status[22] || !$past(rx_wr_ev)) && (status[16] || !$past(tx_wr_ev)));
endmodule

// File: rtl/commport_mux.sv
module commport_mux
  import cpm_pkg::*;
#(
  parameter int W      = 32,
  parameter int DEPTH  = 512,
  parameter int MARGIN = 128
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        link_sel,
  input  logic                        host_wr_valid,
  input  logic [W-1:0]                host_wr_data,
  output logic                        host_wr_ready,
  output logic                        host_rd_valid,
  output logic [W-1:0]                host_rd_data,
  input  logic                        host_rd_ready,
  output logic [CPM_LINKS-1:0]        lk_tx_valid,
  output logic [CPM_LINKS-1:0][W-1:0] lk_tx_data,
  input  logic [CPM_LINKS-1:0]        lk_tx_ready,
  input  logic [CPM_LINKS-1:0]        lk_rx_valid,
  input  logic [CPM_LINKS-1:0][W-1:0] lk_rx_data,
  output logic [CPM_LINKS-1:0]        lk_rx_ready,
  input  logic [CPM_LINKS-1:0]        lk_token,
  output logic [31:0]                 status
);
  logic [W-1:0] tx_head, rx_word;
  logic tx_empty, tx_full, tx_ae, tx_af, tx_wr_fail, tx_rd_fail_unused;
  logic rx_empty, rx_full, rx_ae, rx_af, rx_wr_fail, rx_rd_fail;
  logic tx_pop, tx_pull_fail, rx_push;
  logic [CPM_LINKS-1:0] idle;

  cpm_fifo #(.W(W), .DEPTH(DEPTH), .MARGIN(MARGIN)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(host_wr_valid), .wdata(host_wr_data),
    .pop(tx_pop), .rdata(tx_head),
    .empty(tx_empty), .full(tx_full), .aempty(tx_ae), .afull(tx_af),
    .push_fail(tx_wr_fail), .pop_fail(tx_rd_fail_unused)
  );

  cpm_fifo #(.W(W), .DEPTH(DEPTH), .MARGIN(MARGIN)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .wdata(rx_word),
    .pop(host_rd_ready), .rdata(host_rd_data),
    .empty(rx_empty), .full(rx_full), .aempty(rx_ae), .afull(rx_af),
    .push_fail(rx_wr_fail), .pop_fail(rx_rd_fail)
  );

  cpm_link_mux #(.W(W)) u_mux (
    .clk(clk), .rst_n(rst_n), .sel(link_sel),
    .tx_avail(!tx_empty), .tx_head(tx_head),
    .tx_pop(tx_pop), .tx_pull_fail(tx_pull_fail),
    .rx_room(!rx_full), .rx_push(rx_push), .rx_word(rx_word),
    .lk_tx_valid(lk_tx_valid), .lk_tx_data(lk_tx_data), .lk_tx_ready(lk_tx_ready),
    .lk_rx_valid(lk_rx_valid), .lk_rx_data(lk_rx_data), .lk_rx_ready(lk_rx_ready),
    .idle(idle)
  );

  cpm_status u_status (
    .clk(clk), .rst_n(rst_n), .token(lk_token), .idle(idle),
    .rx_aempty(rx_ae), .rx_afull(rx_af), .rx_empty(rx_empty), .rx_full(rx_full),
    .tx_aempty(tx_ae), .tx_afull(tx_af), .tx_empty(tx_empty), .tx_full(tx_full),
    .rx_rd_ev(rx_rd_fail), .rx_wr_ev(rx_wr_fail),
    .tx_rd_ev(tx_pull_fail), .tx_wr_ev(tx_wr_fail),
    .status(status)
  );

  assign host_wr_ready = !tx_full;
  assign host_rd_valid = !rx_empty;
endmodule

// File: tb/commport_mux_tb.sv
module commport_mux_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_sel = 1'b0;
  logic host_wr_valid = 1'b0;
  logic [31:0] host_wr_data = '0;
  logic host_wr_ready, host_rd_valid;
  logic [31:0] host_rd_data;
  logic host_rd_ready = 1'b0;
  logic [1:0] lk_tx_valid;
  logic [1:0][31:0] lk_tx_data;
  logic [1:0] lk_tx_ready = '0;
  logic [1:0] lk_rx_valid = '0;
  logic [1:0][31:0] lk_rx_data = '0;
  logic [1:0] lk_rx_ready;
  logic [1:0] lk_token = '0;
  logic [31:0] status;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  commport_mux u_dut (
    .clk(clk), .rst_n(rst_n), .link_sel(link_sel),
    .host_wr_valid(host_wr_valid), .host_wr_data(host_wr_data), .host_wr_ready(host_wr_ready),
    .host_rd_valid(host_rd_valid), .host_rd_data(host_rd_data), .host_rd_ready(host_rd_ready),
    .lk_tx_valid(lk_tx_valid), .lk_tx_data(lk_tx_data), .lk_tx_ready(lk_tx_ready),
    .lk_rx_valid(lk_rx_valid), .lk_rx_data(lk_rx_data), .lk_rx_ready(lk_rx_ready),
    .lk_token(lk_token), .status(status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_push(input logic [31:0] d);
    @(negedge clk); host_wr_valid = 1'b1; host_wr_data = d;
    @(negedge clk); host_wr_valid = 1'b0;
  endtask

  task automatic host_pop(output logic [31:0] d, output logic v);
    @(negedge clk); host_rd_ready = 1'b1; #1; d = host_rd_data; v = host_rd_valid;
    @(negedge clk); host_rd_ready = 1'b0;
  endtask

  task automatic link_take(input int ch, output logic [31:0] d, output logic v);
    @(negedge clk); lk_tx_ready[ch] = 1'b1; #1; d = lk_tx_data[ch]; v = lk_tx_valid[ch];
    @(negedge clk); lk_tx_ready[ch] = 1'b0;
  endtask

  task automatic link_give(input int ch, input logic [31:0] d);
    @(negedge clk); lk_rx_valid[ch] = 1'b1; lk_rx_data[ch] = d;
    @(negedge clk); lk_rx_valid[ch] = 1'b0;
  endtask

  task automatic settle;
    @(negedge clk); #1;
  endtask

  localparam logic [32:0] VEC [8] = '{
    {1'b0, 32'h0000_0001}, {1'b1, 32'hFFFF_FFFE}, {1'b0, 32'hA5A5_5A5A},
    {1'b1, 32'h8000_0000}, {1'b1, 32'h1234_5678}, {1'b0, 32'h0000_0000},
    {1'b0, 32'hDEAD_BEEF}, {1'b1, 32'h7FFF_FFFF}
  };

  initial begin
    #(5 * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R7 reset value
    chk("R7 reset status", status, 32'h5A28A000);
    chk("R1 wr_ready after reset", {31'b0, host_wr_ready}, 32'd1);
    chk("R2 rd_valid after reset", {31'b0, host_rd_valid}, 32'd0);

    // R5 token bits
    lk_token = 2'b01; #1;
    chk("R5 token link0", status[31:28], 4'b1101);
    lk_token = 2'b10; #1;
    chk("R5 token link1", status[31:28], 4'b0111);
    lk_token = 2'b00;

    // vector table: R1 R2 R3 round trips on both links
    for (int i = 0; i < 8; i++) begin
      link_sel = VEC[i][32];
      host_push(VEC[i][31:0]);
      #1;
      chk("R3 off link tx valid", {31'b0, lk_tx_valid[!link_sel]}, 32'd0);
      link_take(int'(link_sel), d, v);
      chk("R1 tx valid on link", {31'b0, v}, 32'd1);
      chk("R1 tx word", d, VEC[i][31:0]);
      link_give(int'(link_sel), ~VEC[i][31:0]);
      host_pop(d, v);
      chk("R2 rd valid", {31'b0, v}, 32'd1);
      chk("R2 rd word", d, ~VEC[i][31:0]);
    end

    // R4 switch between transfers keeps order
    link_sel = 1'b0;
    host_push(32'hAAAA_0001);
    host_push(32'hAAAA_0002);
    host_push(32'hAAAA_0003);
    link_take(0, d, v);
    chk("R4 first word on link0", d, 32'hAAAA_0001);
    @(negedge clk); link_sel = 1'b1; #1;
    chk("R4 link0 frozen", {31'b0, lk_tx_valid[0]}, 32'd0);
    chk("R4 link1 offers next", lk_tx_data[1], 32'hAAAA_0002);
    // R12 idle: selected link1 busy, link0 deselected
    chk("R12 idle bits", {28'b0, status[30], status[28]}, 32'b10);
    link_take(1, d, v);
    chk("R4 second word on link1", d, 32'hAAAA_0002);
    @(negedge clk); link_sel = 1'b0;
    link_take(0, d, v);
    chk("R4 third word back on link0", d, 32'hAAAA_0003);
    settle();
    chk("R12 idle when empty", {28'b0, status[30], status[28]}, 32'b11);

    // R3 deselected receive ignored
    @(negedge clk); lk_rx_valid[1] = 1'b1; lk_rx_data[1] = 32'h5555_0000; #1;
    chk("R3 off link rx ready", {31'b0, lk_rx_ready[1]}, 32'd0);
    chk("R12 selected link idle with off-link valid", {31'b0, status[30]}, 32'd1);
    @(negedge clk); lk_rx_valid[1] = 1'b0; #1;
    chk("R3 no word stored from off link", {31'b0, host_rd_valid}, 32'd0);

    // Fill transmit FIFO: R8 R9 R13 R11
    for (int i = 0; i < 512; i++) begin
      host_push(i);
      #1;
      if (i == 127) chk("R8 tx aempty at 128", {31'b0, status[21]}, 32'd1);
      if (i == 128) chk("R8 tx aempty at 129", {31'b0, status[21]}, 32'd0);
      if (i == 382) chk("R9 tx afull at 383", {31'b0, status[20]}, 32'd0);
      if (i == 383) chk("R9 tx afull at 384", {31'b0, status[20]}, 32'd1);
      if (i == 510) chk("R13 tx not full at 511", {31'b0, status[18]}, 32'd0);
    end
    chk("R13 tx full at 512", {31'b0, status[18]}, 32'd1);
    chk("R7 inverted tx full", {28'b0, status[15:12]}, 32'b0000);
    chk("R1 wr_ready low when full", {31'b0, host_wr_ready}, 32'd0);
    chk("R11 no tx wr err yet", {31'b0, status[16]}, 32'd0);
    host_push(32'hBAD0_BAD0);
    #1;
    chk("R11 tx write error set", {31'b0, status[16]}, 32'd1);
    begin
      int bad = 0;
      for (int i = 0; i < 512; i++) begin
        link_take(0, d, v);
        if (d !== i || v !== 1'b1) bad++;
      end
      chk("R11 drained sequence intact", bad, 0);
    end
    settle();
    chk("R11 refused word not stored", {31'b0, status[19]}, 32'd1);
    chk("R11 tx write error sticky", {31'b0, status[16]}, 32'd1);

    // R10 link pull on empty transmit FIFO
    chk("R10 no tx rd err yet", {31'b0, status[17]}, 32'd0);
    @(negedge clk); lk_tx_ready[0] = 1'b1;
    @(negedge clk); lk_tx_ready[0] = 1'b0; #1;
    chk("R10 tx read error set", {31'b0, status[17]}, 32'd1);
    chk("R10 tx still empty", {31'b0, status[19]}, 32'd1);

    // Fill receive FIFO: R8 R9 R13 R11
    for (int i = 0; i < 512; i++) begin
      link_give(0, 32'h1000_0000 + i);
      #1;
      if (i == 127) chk("R8 rx aempty at 128", {31'b0, status[27]}, 32'd1);
      if (i == 383) chk("R9 rx afull at 384", {31'b0, status[26]}, 32'd1);
    end
    chk("R13 rx full", {31'b0, status[24]}, 32'd1);
    chk("R7 inverted rx empty bits", {28'b0, status[15:12]}, 32'b1111);
    chk("R7 low bits zero", {20'b0, status[11:0]}, 32'd0);
    chk("R3 rx ready low when full", {31'b0, lk_rx_ready[0]}, 32'd0);
    link_give(0, 32'hBAD1_BAD1);
    #1;
    chk("R11 rx write error set", {31'b0, status[22]}, 32'd1);
    begin
      int bad = 0;
      for (int i = 0; i < 512; i++) begin
        host_pop(d, v);
        if (d !== 32'h1000_0000 + i || v !== 1'b1) bad++;
      end
      chk("R2 rx drained in order", bad, 0);
    end
    settle();
    chk("R11 refused rx word not stored", {31'b0, host_rd_valid}, 32'd0);

    // R10 host pop on empty receive FIFO
    chk("R10 no rx rd err yet", {31'b0, status[23]}, 32'd0);
    host_pop(d, v);
    settle();
    chk("R10 rx read error set", {31'b0, status[23]}, 32'd1);
    chk("R6 error nibble", {28'b0, status[23:22], status[17:16]}, 32'b1111);
    repeat (3) @(negedge clk);
    #1;
    chk("R10 rx read error sticky", {31'b0, status[23]}, 32'd1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule